// File: doc/BRIEF.md
# Board Supervisory Reset Sequencer

This block generates the active-low system reset and the active-high data-bus isolation signal for a board that is plugged into a live backplane. Its inputs are clean logic levels: a power-good flag from the output-voltage monitor, two connection-sense lines from short staggered connector pins, an active-low power-on-reset request, an undervoltage-lockout flag and an overcurrent-fault flag.

The reset has two different qualification delays. Before reset is released, power-good has to stay high for a long window. Reset returns after a short window once power-good falls. That short window gives software an early power-fail warning, because power-good drops before reset does. A pulse on power-good in either direction that is shorter than the relevant window leaves reset as it was. The other four sources act without delay. Both windows are counted in ticks from an internal clock-enable prescaler. The prescaler is restarted each time a window opens, so every delay is an exact number of clock cycles: `TICK_DIV*REL_TICKS` to release and `TICK_DIV*FALL_TICKS` to assert.

Top module: `hs_reset_seq`

## Requirements
- R1: While `rst_ni` is low and right after it goes high, `sys_rst_no` is 0 and `bus_dis_o` is 1.
- R2: A hard source asserts reset at the next clock edge. The hard sources are `conn_a_i` high, `conn_b_i` high, `por_ni` low, `uvlo_i` high and `fault_i` high.
- R3: When `pwr_good_i` is high and no hard source is present, `sys_rst_no` goes to 1 at the clock edge that is the `TICK_DIV*REL_TICKS`-th consecutive edge sampling that condition.
- R4: A high pulse on `pwr_good_i` that is shorter than `TICK_DIV*REL_TICKS` edges does not release reset. The next high period is counted again from zero.
- R5: If a hard source appears during the release window, the window restarts from zero once the source clears.
- R6: When `sys_rst_no` is 1 and `pwr_good_i` is sampled low with no hard source present, `sys_rst_no` goes to 0 at the `TICK_DIV*FALL_TICKS`-th consecutive low edge.
- R7: A low pulse on `pwr_good_i` that is shorter than `TICK_DIV*FALL_TICKS` edges leaves `sys_rst_no` at 1. The next low period is counted again from zero.
- R8: `bus_dis_o` is always the inverse of `sys_rst_no`. It falls on the same edge at which reset is released.
- R9: Reset is never released while a hard source is present, however long `pwr_good_i` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| pwr_good_i | input | 1 | Output-voltage power-good flag |
| conn_a_i | input | 1 | Connection sense A, high when the board is not seated |
| conn_b_i | input | 1 | Connection sense B, high when the board is not seated |
| por_ni | input | 1 | Power-on-reset request, active low |
| uvlo_i | input | 1 | Supply undervoltage lockout flag |
| fault_i | input | 1 | Overcurrent fault flag |
| sys_rst_no | output | 1 | System reset, active low |
| bus_dis_o | output | 1 | Data-bus disable, active high |

## Verification
The hardest cases are the restart conditions. One is a power-good pulse that lasts exactly one edge less than a window and is followed by a second, full-length period. The other is a hard source that arrives in the middle of a release window. In both cases the only visible sign is the exact edge at which reset changes. The bench therefore drives inputs on falling clock edges and counts rising edges from the first edge that samples the new level. It stops one edge short of the window, holds reset there, reverses the input, and then checks both the edge before and the edge of the transition in the next full window.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/hs_src_merge.sv
module hs_src_merge (
  input  logic conn_a_i,
  input  logic conn_b_i,
  input  logic por_ni,
  input  logic uvlo_i,
  input  logic fault_i,
  output logic hard_o
);
  logic [4:0] src;

  assign src    = {conn_a_i, conn_b_i, ~por_ni, uvlo_i, fault_i};
  assign hard_o = |src;
endmodule

// File: rtl/hs_qual_timer.sv
module hs_qual_timer #(
  parameter int DIV   = 4,
  parameter int TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int PW = hs_pkg::cnt_w(DIV);
  localparam int CW = hs_pkg::cnt_w(TICKS);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  // prescaler restarts with each window, so delays are exact in cycles
  assign tick     = run_i && (pre_q == PRE_LAST);
  assign expire_o = tick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/hs_reset_seq.sv
module hs_reset_seq #(
  parameter int TICK_DIV   = 4,
  parameter int REL_TICKS  = 50,
  parameter int FALL_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic conn_a_i,
  input  logic conn_b_i,
  input  logic por_ni,
  input  logic uvlo_i,
  input  logic fault_i,
  output logic sys_rst_no,
  output logic bus_dis_o
);
  import hs_pkg::*;

  seq_state_e state_q, state_d;
  logic       hard;
  logic       rel_run, rel_exp;
  logic       fall_run, fall_exp;

  hs_src_merge u_merge (
    .conn_a_i (conn_a_i),
    .conn_b_i (conn_b_i),
    .por_ni   (por_ni),
    .uvlo_i   (uvlo_i),
    .fault_i  (fault_i),
    .hard_o   (hard)
  );

  assign rel_run  = (state_q == ST_HOLD) && pwr_good_i && !hard;
  assign fall_run = (state_q == ST_RUN) && !pwr_good_i && !hard;

  hs_qual_timer #(.DIV(TICK_DIV), .TICKS(REL_TICKS)) u_rel_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (rel_run),
    .expire_o (rel_exp)
  );

  hs_qual_timer #(.DIV(TICK_DIV), .TICKS(FALL_TICKS)) u_fall_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (fall_run),
    .expire_o (fall_exp)
  );

  always_comb begin
    state_d = state_q;
    if (hard)                                state_d = ST_HOLD;
    else if (state_q == ST_HOLD && rel_exp)  state_d = ST_RUN;
    else if (state_q == ST_RUN && fall_exp)  state_d = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  assign sys_rst_no = (state_q == ST_RUN);
  assign bus_dis_o  = (state_q == ST_HOLD);
endmodule

// File: rtl/hs_reset_seq_chk.sv
module hs_reset_seq_chk #(
  parameter int TICK_DIV   = 4,
  parameter int REL_TICKS  = 50,
  parameter int FALL_TICKS = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic conn_a_i,
  input logic conn_b_i,
  input logic por_ni,
  input logic uvlo_i,
  input logic fault_i,
  input logic sys_rst_no,
  input logic bus_dis_o
);
  localparam int REL_CYC  = TICK_DIV * REL_TICKS;
  localparam int FALL_CYC = TICK_DIV * FALL_TICKS;
  localparam int HW = $clog2(REL_CYC + 1);
  localparam int LW = $clog2(FALL_CYC + 1);

  logic          hard;
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  assign hard = conn_a_i | conn_b_i | ~por_ni | uvlo_i | fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (pwr_good_i && !hard) begin
        if (hi_cnt != HW'(REL_CYC)) hi_cnt <= hi_cnt + 1'b1;
      end else hi_cnt <= '0;
      if (!pwr_good_i) begin
        if (lo_cnt != LW'(FALL_CYC)) lo_cnt <= lo_cnt + 1'b1;
      end else lo_cnt <= '0;
    end
  end

  // R2
  hard_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard |=> !sys_rst_no);

  // R3
  release_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && pwr_good_i && !hard && hi_cnt == HW'(REL_CYC - 1)) |=> sys_rst_no);

  // R4
  early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && !(pwr_good_i && !hard && hi_cnt == HW'(REL_CYC - 1))) |=> !sys_rst_no);

  // R6
  fall_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && !pwr_good_i && !hard && lo_cnt == LW'(FALL_CYC - 1)) |=> !sys_rst_no);

  // R7
  low_glitch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && !hard && !(!pwr_good_i && lo_cnt == LW'(FALL_CYC - 1))) |=> sys_rst_no);
endmodule

bind hs_reset_seq hs_reset_seq_chk #(
  .TICK_DIV   (TICK_DIV),
  .REL_TICKS  (REL_TICKS),
  .FALL_TICKS (FALL_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .conn_a_i   (conn_a_i),
  .conn_b_i   (conn_b_i),
  .por_ni     (por_ni),
  .uvlo_i     (uvlo_i),
  .fault_i    (fault_i),
  .sys_rst_no (sys_rst_no),
  .bus_dis_o  (bus_dis_o)
);

// File: tb/tb_hs_reset_seq.sv
`timescale 1ns/1ps
module tb_hs_reset_seq;
  localparam int TICK_DIV   = 4;
  localparam int REL_TICKS  = 50;
  localparam int FALL_TICKS = 3;
  localparam int REL_CYC    = TICK_DIV * REL_TICKS;
  localparam int FALL_CYC   = TICK_DIV * FALL_TICKS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b0;
  logic conn_a_i = 1'b1;
  logic conn_b_i = 1'b1;
  logic por_ni = 1'b1;
  logic uvlo_i = 1'b0;
  logic fault_i = 1'b0;
  logic sys_rst_no, bus_dis_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_reset_seq #(
    .TICK_DIV(TICK_DIV), .REL_TICKS(REL_TICKS), .FALL_TICKS(FALL_TICKS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .conn_a_i(conn_a_i), .conn_b_i(conn_b_i), .por_ni(por_ni),
    .uvlo_i(uvlo_i), .fault_i(fault_i),
    .sys_rst_no(sys_rst_no), .bus_dis_o(bus_dis_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // advance n rising edges, then settle at the falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic seat();
    conn_a_i = 1'b0; conn_b_i = 1'b0; por_ni = 1'b1;
    uvlo_i = 1'b0; fault_i = 1'b0;
  endtask

  task automatic do_release(input string req);
    pwr_good_i = 1'b1;
    step(REL_CYC - 1);
    chk({req, " one edge before release"}, sys_rst_no, 1'b0);
    step(1);
    chk({req, " release edge"}, sys_rst_no, 1'b1);
    chk("R8 bus enable at release", bus_dis_o, 1'b0);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 rst low sys_rst_no", sys_rst_no, 1'b0);
    chk("R1 rst low bus_dis_o", bus_dis_o, 1'b1);
    rst_ni = 1'b1;
    step(1);
    chk("R1 after rst sys_rst_no", sys_rst_no, 1'b0);
    chk("R8 after rst bus_dis_o", bus_dis_o, 1'b1);
  endtask

  task automatic t_hard_hold();
    pwr_good_i = 1'b1;
    step(REL_CYC + 20);
    chk("R9 unseated board stays in reset", sys_rst_no, 1'b0);
    chk("R9 bus stays disabled", bus_dis_o, 1'b1);
    seat();
    do_release("R3");
  endtask

  task automatic t_hi_glitch();
    pwr_good_i = 1'b0;
    step(FALL_CYC);
    chk("R6 reset before glitch test", sys_rst_no, 1'b0);
    pwr_good_i = 1'b1;
    step(REL_CYC - 1);
    pwr_good_i = 1'b0;
    step(3);
    chk("R4 short high pulse no release", sys_rst_no, 1'b0);
    do_release("R4 restart");
  endtask

  task automatic t_hard_restart();
    pwr_good_i = 1'b0;
    step(FALL_CYC);
    pwr_good_i = 1'b1;
    step(REL_CYC / 2);
    conn_a_i = 1'b1;
    step(1);
    conn_a_i = 1'b0;
    step(REL_CYC - 1);
    chk("R5 window restarted after hard source", sys_rst_no, 1'b0);
    step(1);
    chk("R5 release after full window", sys_rst_no, 1'b1);
  endtask

  task automatic t_sources();
    for (int s = 0; s < 5; s++) begin
      case (s)
        0: conn_a_i = 1'b1;
        1: conn_b_i = 1'b1;
        2: por_ni   = 1'b0;
        3: uvlo_i   = 1'b1;
        default: fault_i = 1'b1;
      endcase
      step(1);
      chk($sformatf("R2 source %0d asserts next edge", s), sys_rst_no, 1'b0);
      chk("R8 bus disabled with source", bus_dis_o, 1'b1);
      seat();
      do_release("R3");
    end
  endtask

  task automatic t_fall();
    pwr_good_i = 1'b0;
    step(FALL_CYC - 1);
    chk("R6 one edge before assert", sys_rst_no, 1'b1);
    step(1);
    chk("R6 assert edge", sys_rst_no, 1'b0);
    chk("R8 bus disabled on fall", bus_dis_o, 1'b1);
    do_release("R3");
  endtask

  task automatic t_lo_glitch();
    pwr_good_i = 1'b0;
    step(FALL_CYC - 1);
    pwr_good_i = 1'b1;
    step(10);
    chk("R7 short low pulse ignored", sys_rst_no, 1'b1);
    pwr_good_i = 1'b0;
    step(FALL_CYC - 1);
    chk("R7 low window restarted", sys_rst_no, 1'b1);
    step(1);
    chk("R6 assert after full low window", sys_rst_no, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hard_hold();
    t_sources();
    t_fall();
    t_hi_glitch();
    t_hard_restart();
    t_lo_glitch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule